// File: doc/BRIEF.md
# Capture/Compare Timer with Byte-Wide Register Access

This peripheral runs a 16-bit up-counter from the system clock and connects it to two input-capture channels and two output-compare channels. A capture channel stores the counter value when its input pin shows the chosen edge. A compare channel watches for the counter to equal a programmed value, and on a match it drives a programmed level onto its output pin. Every event raises a status flag. An interrupt line combines the flags that software has enabled.

Software reaches every 16-bit quantity through an 8-bit register bus, one byte at a time. Lock rules keep each pair of byte accesses coherent. Reading a counter or capture high byte keeps the matching low byte from moving until it is read. Writing a compare high byte stops matching on that channel until the low byte arrives. Capture pins are asynchronous and go through a synchronizer before edge detection.

Top module: `cc_timer`

## Requirements
- R1: Register addresses are: 0 config, 1 interrupt enable, 2 status, 3 counter high, 4 counter low, 5/6 capture 0 high/low, 7/8 capture 1 high/low, 9/10 compare 0 high/low, 11/12 compare 1 high/low. A read returns its byte on `bus_rdata` one clock after the read strobe, and `bus_rdata` holds when no read occurs. After reset every register, flag, pin output and `irq` is zero.
- R2: The counter starts from zero at the first clock after reset. It rises by one every clock and wraps from 0xFFFF to 0. Two snapshots taken N clocks apart differ by exactly N.
- R3: A counter high-byte read keeps a copy of the low byte as it was at that clock. The next counter low-byte read returns that copy, however many clocks later it comes.
- R4: Status bit 4 is set when the counter wraps from 0xFFFF to 0.
- R5: Config bit i (i = 0, 1) chooses the edge for capture channel i: 1 selects rising and 0 selects falling. On that edge the channel stores the counter value from two clocks after the pin's new level is first sampled, and it sets status bit i.
- R6: The edge that is not selected leaves the capture value and its status bit unchanged.
- R7: Reading a capture high byte freezes that channel's value, and no capture takes place until its low byte is read.
- R8: When the counter equals compare value j (j = 0, 1), output `cmp_pin[j]` takes config bit 2+j on the next clock and status bit 2+j is set.
- R9: Writing a compare high byte disables matching on that channel until its low byte is written. From reset, matching stays disabled until the first low-byte write.
- R10: A status flag clears only when a status read that saw it set is followed by an access to the related low byte. The related low bytes are: a capture low read, a compare low write, or a counter low read for bit 4. A low access with no such earlier status read leaves the flag set.
- R11: `irq` is high one clock after any status bit with its matching interrupt-enable bit set. It stays low while all enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for one clock |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cap_pin | input | N_CAP | Asynchronous capture inputs |
| cmp_pin | output | N_CMP | Registered compare outputs |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter, two capture channels, two compare channels and a two-stage synchronizer. With these, a full counter wrap takes 65,536 clocks, so the overflow flag and its clear sequence are checked within the run. Both channels of each kind sit at their fixed addresses. The bench takes counter snapshots and works out capture values and compare match clocks from them. Random edge selections, delays and match distances are mixed with directed lock and flag-clear sequences.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned REG_CFG     = 0;
  localparam int unsigned REG_IEN     = 1;
  localparam int unsigned REG_STAT    = 2;
  localparam int unsigned REG_CNT_HI  = 3;
  localparam int unsigned REG_CNT_LO  = 4;
  localparam int unsigned REG_CH_BASE = 5;

  // capture channels occupy byte pairs right after the counter
  function automatic int unsigned cap_hi_addr(int unsigned idx);
    return REG_CH_BASE + 2 * idx;
  endfunction

  // compare channels follow all capture channels
  function automatic int unsigned cmp_hi_addr(int unsigned n_cap, int unsigned idx);
    return REG_CH_BASE + 2 * n_cap + 2 * idx;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_hi,
  input  logic                  rd_lo,
  output logic [2*BYTE_W-1:0]   cnt,
  output logic                  wrap,
  output logic [BYTE_W-1:0]     lo_view
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] snap_q;
  logic              snap_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (rd_hi) begin
        snap_q     <= cnt_q[BYTE_W-1:0];
        snap_vld_q <= 1'b1;
      end else if (rd_lo) begin
        snap_vld_q <= 1'b0;
      end
    end
  end

  assign cnt     = cnt_q;
  assign wrap    = &cnt_q;
  assign lo_view = snap_vld_q ? snap_q : cnt_q[BYTE_W-1:0];

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (snap_vld_q && !rd_hi) |=> $stable(snap_q));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pin,
  input  logic                  rise_sel,
  input  logic [2*BYTE_W-1:0]   cnt,
  input  logic                  rd_hi,
  input  logic                  rd_lo,
  output logic [2*BYTE_W-1:0]   latch,
  output logic                  evt
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              lock_q;
  logic [CNT_W-1:0]  latch_q;
  logic              lvl, rise, fall, hit;

  assign lvl  = sync_q[SYNC_N-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign hit  = rise_sel ? rise : fall;
  assign evt  = hit & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      lock_q  <= 1'b0;
      latch_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      prev_q <= lvl;
      if (rd_hi)      lock_q <= 1'b1;
      else if (rd_lo) lock_q <= 1'b0;
      if (evt) latch_q <= cnt;
    end
  end

  assign latch = latch_q;

  p_cap_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(latch_q));
  p_cap_take_r5: assert property (@(posedge clk) disable iff (rst)
    evt |=> latch_q == $past(cnt));
  p_cap_wrong_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (rise_sel && fall) |=> $stable(latch_q));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  level,
  input  logic [2*BYTE_W-1:0]   cnt,
  output logic [2*BYTE_W-1:0]   val,
  output logic                  out,
  output logic                  evt
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] val_q;
  logic             hold_q;
  logic             out_q;

  assign evt = ~hold_q & (cnt == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      hold_q <= 1'b1;
      out_q  <= 1'b0;
    end else begin
      if (wr_hi) begin
        val_q[CNT_W-1:BYTE_W] <= wdata;
        hold_q                <= 1'b1;
      end else if (wr_lo) begin
        val_q[BYTE_W-1:0] <= wdata;
        hold_q            <= 1'b0;
      end
      if (evt) out_q <= level;
    end
  end

  assign val = val_q;
  assign out = out_q;

  p_cmp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> $stable(out_q));
  p_cmp_drive_r8: assert property (@(posedge clk) disable iff (rst)
    evt |=> out_q == $past(level));
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned N_CAP  = 2,
  parameter int unsigned N_CMP  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [N_CAP-1:0]  cap_pin,
  output logic [N_CMP-1:0]  cmp_pin,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int unsigned CNT_W    = 2 * BYTE_W;
  localparam int unsigned CFG_W    = N_CAP + N_CMP;
  localparam int unsigned N_FLAG   = N_CAP + N_CMP + 1;
  localparam int unsigned FLAG_OVF = N_CAP + N_CMP;

  logic [CFG_W-1:0]  cfg_q;
  logic [N_FLAG-1:0] ien_q, stat_q, arm_q;
  logic [BYTE_W-1:0] rdata_q, rd_mux;
  logic              irq_q;

  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [BYTE_W-1:0] cnt_lo_view;
  logic              cnt_hi_rd, cnt_lo_rd, stat_rd;

  logic [CNT_W-1:0]  cap_val [N_CAP];
  logic [N_CAP-1:0]  cap_evt, cap_hi_rd, cap_lo_rd;
  logic [CNT_W-1:0]  cmp_val [N_CMP];
  logic [N_CMP-1:0]  cmp_evt, cmp_hi_wr, cmp_lo_wr;

  logic [N_FLAG-1:0] set_v, low_acc;

  assign cnt_hi_rd = bus_rd && (bus_addr == ADDR_W'(REG_CNT_HI));
  assign cnt_lo_rd = bus_rd && (bus_addr == ADDR_W'(REG_CNT_LO));
  assign stat_rd   = bus_rd && (bus_addr == ADDR_W'(REG_STAT));

  tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .rd_hi(cnt_hi_rd), .rd_lo(cnt_lo_rd),
    .cnt(cnt), .wrap(wrap), .lo_view(cnt_lo_view)
  );

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    assign cap_hi_rd[i] = bus_rd && (bus_addr == ADDR_W'(cap_hi_addr(i)));
    assign cap_lo_rd[i] = bus_rd && (bus_addr == ADDR_W'(cap_hi_addr(i) + 1));
    tmr_capture #(.BYTE_W(BYTE_W), .SYNC_N(SYNC_N)) u_cap (
      .clk(clk), .rst(rst), .pin(cap_pin[i]), .rise_sel(cfg_q[i]),
      .cnt(cnt), .rd_hi(cap_hi_rd[i]), .rd_lo(cap_lo_rd[i]),
      .latch(cap_val[i]), .evt(cap_evt[i])
    );
  end

  for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
    assign cmp_hi_wr[j] = bus_wr && (bus_addr == ADDR_W'(cmp_hi_addr(N_CAP, j)));
    assign cmp_lo_wr[j] = bus_wr && (bus_addr == ADDR_W'(cmp_hi_addr(N_CAP, j) + 1));
    tmr_compare #(.BYTE_W(BYTE_W)) u_cmp (
      .clk(clk), .rst(rst), .wr_hi(cmp_hi_wr[j]), .wr_lo(cmp_lo_wr[j]),
      .wdata(bus_wdata), .level(cfg_q[N_CAP+j]), .cnt(cnt),
      .val(cmp_val[j]), .out(cmp_pin[j]), .evt(cmp_evt[j])
    );
  end

  assign set_v   = {wrap, cmp_evt, cap_evt};
  assign low_acc = {cnt_lo_rd, cmp_lo_wr, cap_lo_rd};

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(REG_CFG))    rd_mux = BYTE_W'(cfg_q);
    if (bus_addr == ADDR_W'(REG_IEN))    rd_mux = BYTE_W'(ien_q);
    if (bus_addr == ADDR_W'(REG_STAT))   rd_mux = BYTE_W'(stat_q);
    if (bus_addr == ADDR_W'(REG_CNT_HI)) rd_mux = cnt[CNT_W-1:BYTE_W];
    if (bus_addr == ADDR_W'(REG_CNT_LO)) rd_mux = cnt_lo_view;
    for (int i = 0; i < N_CAP; i++) begin
      if (bus_addr == ADDR_W'(cap_hi_addr(i)))     rd_mux = cap_val[i][CNT_W-1:BYTE_W];
      if (bus_addr == ADDR_W'(cap_hi_addr(i) + 1)) rd_mux = cap_val[i][BYTE_W-1:0];
    end
    for (int j = 0; j < N_CMP; j++) begin
      if (bus_addr == ADDR_W'(cmp_hi_addr(N_CAP, j)))     rd_mux = cmp_val[j][CNT_W-1:BYTE_W];
      if (bus_addr == ADDR_W'(cmp_hi_addr(N_CAP, j) + 1)) rd_mux = cmp_val[j][BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
      arm_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(REG_CFG)) cfg_q <= bus_wdata[CFG_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(REG_IEN)) ien_q <= bus_wdata[N_FLAG-1:0];
      stat_q <= (stat_q & ~(arm_q & low_acc)) | set_v;
      arm_q  <= stat_rd ? stat_q : (arm_q & ~low_acc);
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= |(stat_q & ien_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[FLAG_OVF]) |-> $past(arm_q[FLAG_OVF] && cnt_lo_rd));
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq_q);
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> stat_q[FLAG_OVF]);
endmodule

// File: tb/tb_cc_timer.sv
`timescale 1ns/1ps
module tb_cc_timer;
  logic       clk = 1'b0, rst = 1'b1, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cap_pin = '0;
  logic [1:0] cmp_pin;
  logic       irq;
  logic [7:0] cfg_sh = '0;
  int n_chk = 0, n_bad = 0;

  cc_timer dut (.clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cmp_pin(cmp_pin), .irq(irq));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge; one access per clock
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(a, h);
    rd(a + 4'd1, l);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_cap(input logic [15:0] c, input int r);
    return c + 16'(4 + r);
  endfunction

  // produce one selected edge on channel ch, r clocks after a counter snapshot
  task automatic cap_shot(input int ch, input bit rise, input int r, output logic [15:0] ev);
    logic [15:0] c;
    cfg_sh[ch] = rise;
    wr(4'd0, cfg_sh);
    cap_pin[ch] = ~rise;
    idle(5);
    rd16(4'd3, c);
    idle(r);
    cap_pin[ch] = rise;
    idle(6);
    ev = exp_cap(c, r);
  endtask

  task automatic cmp_shot(input int ch, input int d, input bit lvl);
    logic [15:0] c, v;
    logic old;
    old = cmp_pin[ch];
    cfg_sh[2+ch] = lvl;
    wr(4'd0, cfg_sh);
    rd16(4'd3, c);
    v = c + 16'(d);
    wr(4'(9 + 2*ch), v[15:8]);
    wr(4'(10 + 2*ch), v[7:0]);
    idle(d - 4);
    check("R8 before match", 32'(cmp_pin[ch]), 32'(old));
    idle(1);
    check("R8 after match", 32'(cmp_pin[ch]), 32'(lvl));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  b, h, l;
    logic [15:0] c1, c2, v, v3, df;
    void'($urandom(32'd7331));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1/R2: counter starts from zero, registers clear
    rd16(4'd3, c1);
    check("R2 first count", 32'(c1), 32'h0);
    rd(4'd0, b); check("R1 cfg reset", 32'(b), 32'h0);
    rd(4'd1, b); check("R1 ien reset", 32'(b), 32'h0);
    rd(4'd2, b); check("R1 stat reset", 32'(b), 32'h0);
    rd16(4'd5, v); check("R1 capture reset", 32'(v), 32'h0);
    check("R1 cmp pins reset", 32'(cmp_pin), 32'h0);
    check("R1 irq reset", 32'(irq), 32'h0);

    // R2: snapshots separated by random gaps
    for (int k = 0; k < 4; k++) begin
      int g;
      g = int'($urandom % 30);
      rd16(4'd3, c1);
      idle(g);
      rd16(4'd3, c2);
      df = c2 - c1;
      check("R2 count step", 32'(df), 32'(g + 2));
    end

    // R3: frozen low byte after a delayed low read
    rd(4'd3, h);
    idle(5);
    rd(4'd4, l);
    rd16(4'd3, c2);
    df = c2 - {h, l};
    check("R3 frozen low byte", 32'(df), 32'd7);

    // R5: random captures, both channels and both edges
    for (int k = 0; k < 12; k++) begin
      int ch, r;
      bit rise;
      ch = int'($urandom % 2); rise = 1'($urandom % 2); r = int'($urandom % 20);
      cap_shot(ch, rise, r, v3);
      rd16(4'(5 + 2*ch), v);
      check("R5 capture value", 32'(v), 32'(v3));
    end

    // R6: non-selected edge on channel 1
    cap_shot(1, 1'b1, 4, v3);
    rd(4'd2, b); rd16(4'd7, v);
    check("R6 setup capture", 32'(v), 32'(v3));
    cap_pin[1] = 1'b0;
    idle(6);
    rd(4'd2, b);
    check("R6 flag unchanged", 32'(b[1]), 32'h0);
    rd16(4'd7, v);
    check("R6 value unchanged", 32'(v), 32'(v3));

    // R7: high read locks capture channel 0
    cap_shot(0, 1'b1, 3, v3);
    rd(4'd5, h);
    cap_pin[0] = 1'b0; idle(5);
    cap_pin[0] = 1'b1; idle(6);
    rd(4'd6, l);
    check("R7 locked value", 32'({h, l}), 32'(v3));
    cap_shot(0, 1'b1, 2, v3);
    rd16(4'd5, v);
    check("R7 capture after unlock", 32'(v), 32'(v3));

    // R10: flag clear needs a status read first
    rd(4'd6, b);
    cap_shot(0, 1'b1, 1, v3);
    rd(4'd6, b);
    rd(4'd2, b);
    check("R10 flag kept without status read", 32'(b[0]), 32'h1);
    rd(4'd6, b);
    rd(4'd2, b);
    check("R10 flag cleared", 32'(b[0]), 32'h0);

    // R11: interrupt on enabled flag only
    wr(4'd1, 8'h00);
    cap_shot(0, 1'b1, 0, v3);
    check("R11 irq masked", 32'(irq), 32'h0);
    wr(4'd1, 8'h01);
    idle(2);
    check("R11 irq raised", 32'(irq), 32'h1);
    rd(4'd2, b); rd(4'd6, b);
    idle(1);
    check("R11 irq dropped", 32'(irq), 32'h0);
    wr(4'd1, 8'h00);

    // R9: high write holds off a due match
    begin
      logic [15:0] c;
      logic old;
      old = cmp_pin[0];
      cfg_sh[2] = ~old;
      wr(4'd0, cfg_sh);
      rd(4'd2, b); rd(4'd10, b);
      rd(4'd9, b);
      rd16(4'd3, c);
      v = c + 16'd40;
      wr(4'd9, v[15:8]);
      wr(4'd10, v[7:0]);
      wr(4'd9, v[15:8]);
      idle(42);
      check("R9 no drive while held", 32'(cmp_pin[0]), 32'(old));
      rd(4'd2, b);
      check("R9 no flag while held", 32'(b[2]), 32'h0);
      wr(4'd10, v[7:0]);
    end

    // R8: directed and random compare matches
    cmp_shot(1, 8, ~cmp_pin[1]);
    rd(4'd2, b);
    check("R8 flag set", 32'(b[3]), 32'h1);
    for (int k = 0; k < 8; k++) begin
      int ch;
      ch = int'($urandom % 2);
      cmp_shot(ch, 8 + int'($urandom % 50), ~cmp_pin[ch]);
    end

    // R4: overflow flag around the wrap
    begin
      int kk;
      rd16(4'd3, c1);
      kk = 65537 - int'(c1);
      idle(kk - 12);
      rd(4'd2, b);
      check("R4 no overflow yet", 32'(b[4]), 32'h0);
      idle(10);
      rd(4'd2, b);
      check("R4 overflow flag", 32'(b[4]), 32'h1);
      rd(4'd4, b);
      rd(4'd2, b);
      check("R10 overflow cleared", 32'(b[4]), 32'h0);
    end
    summary();
  end
endmodule